// File: doc/BRIEF.md
# Burst-Fill Direct-Mapped Instruction Cache

This block is a 256-byte read-only instruction cache for a 32-bit fetch unit. It has sixteen lines, each holding four 32-bit words, and each line has one tag and one valid flag. A fetch address selects exactly one line, so the cache is direct mapped. Two addresses that are equal modulo 256 share a line and push each other out. A hit returns the word combinationally in the cycle the request is presented.

On a miss the cache fetches the whole line in one burst. It puts the line-aligned address on the memory side and takes four beats, word 0 first and word 3 last. Memory paces each beat with a valid strobe. A typical memory gives the first beat two clocks after the request and each later beat one clock after the one before it. The requested word goes to the processor in the cycle its beat arrives. The line's tag and valid flag are committed only when the last beat is taken.

A one-cycle invalidate pulse empties the whole cache. If the pulse arrives while a burst is running, the line being filled is also left invalid. While a burst is running, no new fetch is served.

Top module: `line_burst_icache`

## Requirements
- R1: After a synchronous active-low reset, `cpu_ready` and `mem_req` are low and every line is invalid, so the first fetch of any address misses.
- R2: The fetch address is decoded as follows: bits [3:2] select the word, bits [7:4] select the line and bits [31:8] form the tag. Bits [1:0] have no effect on the lookup.
- R3: When no burst is running and `cpu_req` addresses a valid line whose tag matches, `cpu_ready` is high in that same cycle with the stored word on `cpu_rdata`, and `mem_req` stays low.
- R4: On a miss, `mem_req` rises in the next cycle with `mem_addr` equal to the fetch address with bits [3:0] cleared. Both stay unchanged until the fourth beat is taken, and `mem_req` is low in the following cycle.
- R5: The four beats of a burst are written into words 0, 1, 2 and 3 of the line in that order. Afterwards, all four words hit with the data delivered.
- R6: During a burst, `cpu_ready` is high only in the cycle in which the beat for the requested word (address bits [3:2]) is taken, and `cpu_rdata` then equals `mem_rdata`.
- R7: The line is never valid before its last beat. While a burst is running, a new fetch gets no `cpu_ready`, and it is served only after the burst ends.
- R8: Filling a line replaces whatever was stored at that line before, so two addresses with the same bits [7:4] and different tags evict each other.
- R9: An `inv_all` pulse makes every line invalid from the next cycle on. A hit presented in the same cycle as the pulse is still served.
- R10: An `inv_all` pulse during a burst, including in the cycle of its last beat, leaves that line invalid, although the critical word is still delivered.
- R11: Beats may arrive with idle cycles between them, and the cache waits for each `mem_valid`. A `mem_valid` seen while `mem_req` is low changes neither the outputs nor the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inv_all | input | 1 | One-cycle pulse that invalidates every line |
| cpu_req | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | 32 | Fetch byte address |
| cpu_ready | output | 1 | Fetch data valid this cycle |
| cpu_rdata | output | 32 | Fetched word |
| mem_req | output | 1 | Burst request, high for the whole burst |
| mem_addr | output | 32 | Line-aligned burst start address |
| mem_valid | input | 1 | Beat strobe from memory |
| mem_rdata | input | 32 | Beat data |

## Verification
The bench targets the cases that a burst fill gets wrong most easily.

- **Critical word in the middle of the line.** A design that answered on the first beat would return the wrong word. One that answered only at the end of the burst would be late by a known number of cycles.
- **Fetch issued during the rest of a burst.** The bench requests the next word of the same line straight after the critical word. A design that marked the line valid early would hit on a word not yet written.
- **Invalidate during a burst and in the same cycle as a hit.** These show whether the in-flight line is cancelled, and whether the clear is applied one cycle too soon.
- **Gapped beats and stray memory strobes while idle.** These would expose a design that counts clocks instead of beats, or that writes when no burst is running.

// File: rtl/icache_pkg.sv
// Package: shared types for the burst-fill instruction cache.
// Assumes: nothing beyond IEEE 1800-2017.
package icache_pkg;

    // State of the line-fill sequencer.
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

endpackage

// File: rtl/icache_tag_store.sv
// Module: icache_tag_store
// Holds one valid flag and one tag per line. The read port is
// combinational. A write sets the tag and the valid flag of one line.
// The clear input drops every valid flag in one cycle and takes
// priority over a write in the same cycle.
// Assumes: at most one write per cycle.
module icache_tag_store #(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 24,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [NUM_LINES-1:0] line_valid;
    logic [TAG_W-1:0]     line_tag [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Valid flag of one line: cleared by reset or clear, set by a commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_valid[g] <= 1'b0;
            end else if (clr_all) begin
                line_valid[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                line_valid[g] <= 1'b1;
            end
        end

        // Tag of one line: loaded on a commit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_tag[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                line_tag[g] <= wr_tag;
            end
        end
    end

    // Combinational lookup of the addressed line.
    always_comb begin
        rd_valid = line_valid[rd_idx];
        rd_tag   = line_tag[rd_idx];
    end

endmodule

// File: rtl/icache_data_store.sv
// Module: icache_data_store
// Word storage for all lines, with one combinational read port and one
// write port. It has no reset: a word is read only after the valid flag
// of its line has been set, which happens after the word was written.
// Assumes: the write and read ports address words as {line, word}.
module icache_data_store #(
    parameter int NUM_LINES  = 16,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int DEPTH     = NUM_LINES * LINE_WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [DEPTH];

    // Write one beat into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[{wr_idx, wr_word}] <= wr_data;
        end
    end

    // Combinational read for the hit path.
    always_comb begin
        rd_data = words[{rd_idx, rd_word}];
    end

endmodule

// File: rtl/icache_fill_ctrl.sv
// Module: icache_fill_ctrl
// Sequences one line fill. A miss seen while idle latches the line
// index, tag and wanted word, and starts a burst. Each memory beat
// writes the next word of the line. The beat matching the wanted word
// is flagged as critical. The last beat commits tag and valid unless an
// invalidate was seen during the burst.
// Assumes: memory returns exactly LINE_WORDS beats per burst, in order.
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = 24,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              lookup_req,
    input  logic              lookup_hit,
    input  logic [IDX_W-1:0]  lookup_idx,
    input  logic [TAG_W-1:0]  lookup_tag,
    input  logic [WSEL_W-1:0] lookup_word,
    input  logic              beat_valid,
    output logic              busy,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [WSEL_W-1:0] fill_beat,
    output logic              beat_wr,
    output logic              beat_critical,
    output logic              line_commit
);

    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    fill_state_e       state_q;
    logic [WSEL_W-1:0] want_q;
    logic              kill_q;

    // Fill sequencer: start on a miss, count beats, return to idle after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FILL_IDLE;
            fill_idx  <= '0;
            fill_tag  <= '0;
            fill_beat <= '0;
            want_q    <= '0;
            kill_q    <= 1'b0;
        end else begin
            case (state_q)
                FILL_IDLE: begin
                    if (lookup_req && !lookup_hit) begin
                        state_q   <= FILL_BUSY;
                        fill_idx  <= lookup_idx;
                        fill_tag  <= lookup_tag;
                        want_q    <= lookup_word;
                        fill_beat <= '0;
                        kill_q    <= 1'b0;
                    end
                end
                FILL_BUSY: begin
                    if (inv_all) begin
                        kill_q <= 1'b1;
                    end
                    if (beat_valid) begin
                        fill_beat <= fill_beat + 1'b1;
                        if (fill_beat == LAST_BEAT) begin
                            state_q <= FILL_IDLE;
                        end
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    // Per-beat strobes derived from the sequencer state.
    always_comb begin
        busy          = (state_q == FILL_BUSY);
        beat_wr       = busy && beat_valid;
        beat_critical = beat_wr && (fill_beat == want_q);
        line_commit   = beat_wr && (fill_beat == LAST_BEAT) && !kill_q;
    end

endmodule

// File: rtl/line_burst_icache.sv
// Module: line_burst_icache (top)
// Direct-mapped instruction cache with whole-line burst fill. It splits
// the fetch address, looks up the tag store, serves hits from the data
// store in the same cycle and hands misses to the fill sequencer. During
// a burst, the critical word is forwarded straight from the memory bus.
// Assumes: the processor holds cpu_req and cpu_addr until cpu_ready;
// memory keeps beats in order and sends none unless mem_req is high.
module line_burst_icache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int WSEL_W   = $clog2(LINE_WORDS);
    localparam int IDX_W    = $clog2(NUM_LINES);
    localparam int LINE_LSB = BYTE_W + WSEL_W;
    localparam int TAG_LSB  = LINE_LSB + IDX_W;
    localparam int TAG_W    = ADDR_W - TAG_LSB;

    logic [WSEL_W-1:0] req_word;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [BYTE_W-1:0] unused_byte_off;

    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              lookup_hit;

    logic              busy;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic [WSEL_W-1:0] fill_beat;
    logic              beat_wr;
    logic              beat_critical;
    logic              line_commit;

    // Address split into word select, line index and tag.
    always_comb begin
        unused_byte_off = cpu_addr[BYTE_W-1:0];
        req_word        = cpu_addr[LINE_LSB-1:BYTE_W];
        req_idx         = cpu_addr[TAG_LSB-1:LINE_LSB];
        req_tag         = cpu_addr[ADDR_W-1:TAG_LSB];
    end

    icache_tag_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) tags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (inv_all),
        .rd_idx   (req_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .wr_en    (line_commit),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_tag)
    );

    icache_data_store #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .DATA_W     (DATA_W)
    ) data_i (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_word (req_word),
        .rd_data (rd_data),
        .wr_en   (beat_wr),
        .wr_idx  (fill_idx),
        .wr_word (fill_beat),
        .wr_data (mem_rdata)
    );

    // Tag compare for the lookup.
    always_comb begin
        lookup_hit = rd_valid && (rd_tag == req_tag);
    end

    icache_fill_ctrl #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .TAG_W      (TAG_W)
    ) fill_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .inv_all       (inv_all),
        .lookup_req    (cpu_req),
        .lookup_hit    (lookup_hit),
        .lookup_idx    (req_idx),
        .lookup_tag    (req_tag),
        .lookup_word   (req_word),
        .beat_valid    (mem_valid),
        .busy          (busy),
        .fill_idx      (fill_idx),
        .fill_tag      (fill_tag),
        .fill_beat     (fill_beat),
        .beat_wr       (beat_wr),
        .beat_critical (beat_critical),
        .line_commit   (line_commit)
    );

    // Processor response: hit path when idle, forwarded beat when filling.
    always_comb begin
        if (busy) begin
            cpu_ready = beat_critical;
            cpu_rdata = mem_rdata;
        end else begin
            cpu_ready = cpu_req && lookup_hit;
            cpu_rdata = rd_data;
        end
    end

    // Memory request: held for the whole burst at the line-aligned address.
    always_comb begin
        mem_req  = busy;
        mem_addr = {fill_tag, fill_idx, {LINE_LSB{1'b0}}};
    end

endmodule

// File: rtl/icache_checker.sv
// Module: icache_checker
// Port-level protocol checks for line_burst_icache, bound to every
// instance of it. It counts beats and critical responses per burst
// with its own counters.
// Assumes: the same parameters as the cache it is bound to.
module icache_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr
);

    localparam int CNT_W    = $clog2(LINE_WORDS) + 1;
    localparam int LINE_LSB = $clog2(LINE_WORDS) + 2;

    logic [CNT_W-1:0] beat_cnt;
    logic             crit_seen;

    // Count beats and critical responses inside the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !mem_req) begin
            beat_cnt  <= '0;
            crit_seen <= 1'b0;
        end else begin
            if (mem_valid) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
            if (cpu_ready) begin
                crit_seen <= 1'b1;
            end
        end
    end

    // R4: the burst address is line aligned
    assert_line_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LINE_LSB-1:0] == '0));

    // R4: the burst address holds for the whole burst
    assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    // R5: a burst ends only right after its last beat
    assert_full_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> ($past(mem_valid) && ($past(beat_cnt) == CNT_W'(LINE_WORDS - 1))));

    // R6: one critical response per burst
    assert_single_critical_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cpu_ready) |-> !crit_seen);

    // R7: during a burst, ready only accompanies a beat
    assert_ready_with_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cpu_ready) |-> mem_valid);

    // R3: a hit answer needs a request
    assert_hit_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && cpu_ready) |-> cpu_req);

endmodule

bind line_burst_icache icache_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_WORDS (LINE_WORDS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr)
);

// File: tb/line_burst_icache_tb.sv
// Bench for line_burst_icache. A behavioural reference model with plain
// arrays and counters predicts every output each cycle. A memory model
// answers bursts with a two-clock first beat, optionally with gaps, and
// can send stray strobes while idle.
module line_burst_icache_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        inv_all;
    logic        cpu_req;
    logic [31:0] cpu_addr;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit gap_mode = 0;
    bit stray_en = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_burst_icache dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (inv_all),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Memory model: first beat two clocks after the request, then one per clock or gapped.
    initial begin
        logic [31:0] base;
        mem_valid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk); #2;
            if (mem_req) begin
                base = mem_addr;
                mem_valid = 1'b0;
                @(posedge clk); #2;
                for (int b = 0; b < 4; b++) begin
                    if (gap_mode && b > 0) begin
                        mem_valid = 1'b0;
                        @(posedge clk); #2;
                    end
                    mem_valid = 1'b1;
                    mem_rdata = mem_word(base + 32'(4 * b));
                    @(posedge clk); #2;
                end
                mem_valid = 1'b0;
            end else begin
                mem_valid = stray_en;
                mem_rdata = 32'hDEAD_BEEF;
            end
        end
    end

    // Reference model state.
    bit          m_busy;
    bit          m_kill;
    int          m_beat;
    int          m_want;
    logic [31:0] m_base;
    bit          m_valid [16];
    logic [23:0] m_tag   [16];
    logic [31:0] m_data  [64];

    // Model update at each clock edge.
    always @(posedge clk) begin
        int idx;
        int fi;
        bit hit;
        if (!rst_n) begin
            m_busy = 0; m_kill = 0; m_beat = 0; m_want = 0; m_base = '0;
            for (int i = 0; i < 16; i++) m_valid[i] = 0;
        end else begin
            idx = int'(cpu_addr[7:4]);
            hit = m_valid[idx] && (m_tag[idx] == cpu_addr[31:8]);
            if (m_busy) begin
                if (inv_all) m_kill = 1;
                if (mem_valid) begin
                    fi = int'(m_base[7:4]);
                    m_data[fi * 4 + m_beat] = mem_rdata;
                    if (m_beat == 3) begin
                        if (!m_kill) begin
                            m_valid[fi] = 1;
                            m_tag[fi]   = m_base[31:8];
                        end
                        m_busy = 0;
                    end else begin
                        m_beat++;
                    end
                end
            end else if (cpu_req && !hit) begin
                m_busy = 1; m_kill = 0; m_beat = 0;
                m_want = int'(cpu_addr[3:2]);
                m_base = {cpu_addr[31:4], 4'b0};
            end
            if (inv_all) begin
                for (int i = 0; i < 16; i++) m_valid[i] = 0;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        int idx;
        bit er;
        logic [31:0] ed;
        if (rst_n === 1'b1 && !done) begin
            idx = int'(cpu_addr[7:4]);
            if (!m_busy) begin
                er = cpu_req && m_valid[idx] && (m_tag[idx] == cpu_addr[31:8]);
                ed = m_data[idx * 4 + int'(cpu_addr[3:2])];
                chk(cpu_ready == er, "R3 hit ready", 32'(cpu_ready), 32'(er));
                if (er) chk(cpu_rdata == ed, "R3 hit data", cpu_rdata, ed);
            end else begin
                er = mem_valid && (m_beat == m_want);
                chk(cpu_ready == er, "R6 critical ready", 32'(cpu_ready), 32'(er));
                if (er) chk(cpu_rdata == mem_rdata, "R6 critical data", cpu_rdata, mem_rdata);
            end
            chk(mem_req == m_busy, "R4 mem_req", 32'(mem_req), 32'(m_busy));
            if (m_busy) chk(mem_addr == m_base, "R4 mem_addr", mem_addr, m_base);
        end
    end

    // Issue one fetch and hold it until ready; reports data and wait cycles.
    task automatic fetch(input logic [31:0] a, output logic [31:0] d, output int lat);
        cpu_req  = 1'b1;
        cpu_addr = a;
        lat = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) begin
                d = cpu_rdata;
                break;
            end
            lat++;
        end
        @(posedge clk); #2;
        cpu_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic fetch_expect(input logic [31:0] a, input int exp_lat,
                                input logic [31:0] src, input string req);
        logic [31:0] d;
        int lat;
        fetch(a, d, lat);
        chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
        chk(d == mem_word(src), {req, " data"}, d, mem_word(src));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all actual=timeout expected=completion");
        finish_report();
    end

    // Directed stimulus.
    initial begin
        rst_n = 1'b0; inv_all = 1'b0; cpu_req = 1'b0; cpu_addr = '0;
        repeat (3) @(posedge clk);
        #2;
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R1 ready in reset", 32'(cpu_ready), 32'd0);
        chk(mem_req == 1'b0, "R1 mem_req in reset", 32'(mem_req), 32'd0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        idle(1);

        // R1: cold cache misses; word 0 arrives with the first beat.
        fetch_expect(32'h0000_0100, 2, 32'h0000_0100, "R1 cold miss");
        idle(4);
        // R6: critical word 2 arrives on the third beat.
        fetch_expect(32'h0000_1238, 4, 32'h0000_1238, "R6 critical word");
        idle(3);
        // R5: every word of the filled line now hits.
        fetch_expect(32'h0000_1230, 0, 32'h0000_1230, "R5 word0 hit");
        fetch_expect(32'h0000_1234, 0, 32'h0000_1234, "R5 word1 hit");
        fetch_expect(32'h0000_123C, 0, 32'h0000_123C, "R5 word3 hit");
        // R2: byte offset bits do not change the lookup.
        fetch_expect(32'h0000_1237, 0, 32'h0000_1234, "R2 byte offset");
        // R7: a fetch during the rest of the burst waits for its end.
        fetch_expect(32'h0000_2000, 2, 32'h0000_2000, "R7 miss");
        fetch_expect(32'h0000_2004, 3, 32'h0000_2004, "R7 wait for burst");
        // R8: same index, other tag evicts.
        fetch_expect(32'h0000_2100, 2, 32'h0000_2100, "R8 conflict fill");
        idle(4);
        fetch_expect(32'h0000_2000, 2, 32'h0000_2000, "R8 evicted line");
        idle(4);
        // R9: hit in the pulse cycle is served, then the line is gone.
        inv_all = 1'b1;
        fetch_expect(32'h0000_1230, 0, 32'h0000_1230, "R9 hit with pulse");
        inv_all = 1'b0;
        fetch_expect(32'h0000_1230, 2, 32'h0000_1230, "R9 after invalidate");
        idle(4);
        // R10: a pulse during a burst cancels the line.
        fetch_expect(32'h0000_3000, 2, 32'h0000_3000, "R10 fill");
        inv_all = 1'b1;
        idle(1);
        inv_all = 1'b0;
        idle(4);
        fetch_expect(32'h0000_3004, 3, 32'h0000_3004, "R10 line cancelled");
        idle(4);
        // R11: gapped beats; word 2 arrives after two gaps.
        gap_mode = 1;
        fetch_expect(32'h0000_4008, 6, 32'h0000_4008, "R11 gapped burst");
        idle(6);
        gap_mode = 0;
        // R11: stray strobes while idle change nothing.
        stray_en = 1;
        idle(5);
        stray_en = 0;
        idle(1);
        fetch_expect(32'h0000_4008, 0, 32'h0000_4008, "R11 stray ignored");
        fetch_expect(32'h0000_400C, 0, 32'h0000_400C, "R11 stray ignored w3");
        idle(3);
        finish_report();
    end

endmodule